// File: doc/BRIEF.md
# Byte-Wide Asynchronous Serial Controller

This block moves single characters between a parallel register bus and a pair of asynchronous serial lines. Software programs one control byte, which holds the clock divide ratio, the character format, the transmit control and the receive interrupt enable. It then writes characters to transmit and reads received characters. It polls a status byte, or waits on `irq_o`. Each direction has one holding register and no deeper queue.

The bit rate comes from `rate_tick_i`. This input is a one-cycle enable that is synchronous to `clk_i`, with one pulse per rate-clock period. The divide code selects 1, 16 (`MID_RATIO`) or 64 (`HI_RATIO`) ticks per bit. The fourth divide code holds the whole block in master reset. The control register powers up with that code, so nothing runs until a real divide code is written. Characters go out LSB first: a low start bit, the data, an optional parity bit, then one or two high stop bits.

Top module: `serial_ctl`

## Requirements
- R1: After `rst_ni`, and whenever control bits [1:0] = 11, the block is in master reset. Both shifters are idle. Status bits 0 (receive full) and 1 (transmit empty) read 0. `txd_o` is held at 1, even when break is selected. Data writes are ignored.
- R2: Control bits [1:0] set the bit period in rate ticks: 00 = 1, 01 = `MID_RATIO`, 10 = `HI_RATIO`.
- R3: Control bits [4:2] set the format. 000 is 7 data bits, even parity, 2 stop. 001 is 7 odd 2. 010 is 7 even 1. 011 is 7 odd 1. 100 is 8 data, no parity, 2 stop. 101 is 8 none 1. 110 is 8 even 1. 111 is 8 odd 1. Data goes LSB first after a low start bit. A 7-bit character reads back with bit 7 = 0.
- R4: Control bits [6:5] set the transmit control. 10 drives `rts_o` high; every other code drives it low. 01 enables the transmit interrupt. 11 holds `txd_o` low as a continuous break.
- R5: While `cts_i` is high, status bit 1 reads 0 and no new character starts. A character that is waiting starts once `cts_i` falls.
- R6: In the divide-by-16 and divide-by-64 modes, the receiver checks the start bit half a bit after the falling edge. If the line is high again at that point, the edge is dropped as noise. Each later bit is sampled one bit period after the previous one.
- R7: Status bit 4 (framing error) is set when the first stop bit is received low. Status bit 6 (parity error) is set when the received parity does not match the selected sense.
- R8: If a character completes while status bit 0 is still set, the new character is discarded, the held data is kept, and status bit 5 (overrun) is set.
- R9: A read of the data register (`sel_i` = 1 with `rd_i`) clears status bits 0, 4, 5 and 6.
- R10: `irq_o` is high when either of two conditions holds. Control bit 7 is set and status bit 0 or bit 5 is set. Or the transmit control is 01 and status bit 1 is set. Status bit 7 equals `irq_o`.
- R11: Status bit 2 follows `dcd_i` and status bit 3 follows `cts_i`.
- R12: With `sel_i` = 0, a write goes to the control register and `rdata_o` shows the status. With `sel_i` = 1, a write loads the transmit holding register and `rdata_o` shows the received character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_i | input | 1 | Register select: 0 control/status, 1 data |
| wr_i | input | 1 | Write strobe, one cycle |
| rd_i | input | 1 | Read strobe, one cycle |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, combinational from `sel_i` |
| rate_tick_i | input | 1 | Bit-rate clock enable, synchronous to `clk_i` |
| txd_o | output | 1 | Serial transmit line, idle high |
| rxd_i | input | 1 | Serial receive line, synchronised internally |
| rts_o | output | 1 | Request-to-send level |
| cts_i | input | 1 | Clear-to-send; high blocks transmission |
| dcd_i | input | 1 | Carrier detect, reflected in status |
| irq_o | output | 1 | Interrupt request, active high |

## Verification
A bit counter or divide counter that is off by one shows up on `txd_o` within one character. The low run of the start bit plus zero data bits comes out one bit period too long or too short, and a loopback then returns a shifted byte or a framing error. If the holding register fails to clear, overrun is raised one character later, or status bit 1 stays low. A flag that is not cleared on read shows in the status byte on the very next poll, and through `irq_o` in the same cycle.

// File: rtl/serial_ctl_pkg.sv
package serial_ctl_pkg;

  typedef enum logic [1:0] {
    DIV_ONE  = 2'b00,
    DIV_MID  = 2'b01,
    DIV_HI   = 2'b10,
    DIV_MRST = 2'b11
  } div_e;

  typedef enum logic [1:0] {
    TXC_QUIET  = 2'b00,
    TXC_IRQ    = 2'b01,
    TXC_RTS_HI = 2'b10,
    TXC_BREAK  = 2'b11
  } txc_e;

  typedef struct packed {
    logic d8;
    logic par_en;
    logic par_odd;
    logic two_stop;
  } fmt_t;

  function automatic fmt_t fmt_decode(input logic [2:0] code);
    fmt_t f;
    unique case (code)
      3'b000:  f = '{d8: 1'b0, par_en: 1'b1, par_odd: 1'b0, two_stop: 1'b1};
      3'b001:  f = '{d8: 1'b0, par_en: 1'b1, par_odd: 1'b1, two_stop: 1'b1};
      3'b010:  f = '{d8: 1'b0, par_en: 1'b1, par_odd: 1'b0, two_stop: 1'b0};
      3'b011:  f = '{d8: 1'b0, par_en: 1'b1, par_odd: 1'b1, two_stop: 1'b0};
      3'b100:  f = '{d8: 1'b1, par_en: 1'b0, par_odd: 1'b0, two_stop: 1'b1};
      3'b101:  f = '{d8: 1'b1, par_en: 1'b0, par_odd: 1'b0, two_stop: 1'b0};
      3'b110:  f = '{d8: 1'b1, par_en: 1'b1, par_odd: 1'b0, two_stop: 1'b0};
      default: f = '{d8: 1'b1, par_en: 1'b1, par_odd: 1'b1, two_stop: 1'b0};
    endcase
    return f;
  endfunction

  // start + data + parity + stops
  function automatic logic [3:0] frame_len(input fmt_t f);
    return 4'd1 + (f.d8 ? 4'd8 : 4'd7) + {3'd0, f.par_en} + (f.two_stop ? 4'd2 : 4'd1);
  endfunction

endpackage

// File: rtl/serial_ctl_tx.sv
module serial_ctl_tx
  import serial_ctl_pkg::*;
#(
  parameter int CW = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          tick_i,
  input  logic [CW-1:0] per_m1_i,
  input  fmt_t          fmt_i,
  input  logic          wr_i,
  input  logic [7:0]    wdata_i,
  input  logic          cts_i,
  output logic          hold_full_o,
  output logic          busy_o,
  output logic          line_o
);

  logic [7:0]    hold_q;
  logic          hold_full_q, busy_q;
  logic [11:0]   sh_q, frame;
  logic [3:0]    left_q;
  logic [CW-1:0] cnt_q;
  logic          par, start;

  always_comb begin
    par   = (^(hold_q & (fmt_i.d8 ? 8'hFF : 8'h7F))) ^ fmt_i.par_odd;
    frame = '1;
    frame[0] = 1'b0;
    for (int i = 0; i < 8; i++)
      if (i < 7 || fmt_i.d8) frame[i+1] = hold_q[i];
    if (fmt_i.par_en) begin
      if (fmt_i.d8) frame[9] = par;
      else          frame[8] = par;
    end
  end

  assign start = tick_i && !busy_q && hold_full_q && !cts_i && !clr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q      <= '0;
      hold_full_q <= 1'b0;
      busy_q      <= 1'b0;
      sh_q        <= '1;
      left_q      <= '0;
      cnt_q       <= '0;
    end else if (clr_i) begin
      hold_full_q <= 1'b0;
      busy_q      <= 1'b0;
      sh_q        <= '1;
      left_q      <= '0;
      cnt_q       <= '0;
    end else begin
      if (start) begin
        sh_q        <= frame;
        busy_q      <= 1'b1;
        left_q      <= frame_len(fmt_i);
        cnt_q       <= '0;
        hold_full_q <= 1'b0;
      end else if (busy_q && tick_i) begin
        if (cnt_q == per_m1_i) begin
          cnt_q  <= '0;
          sh_q   <= {1'b1, sh_q[11:1]};
          left_q <= left_q - 4'd1;
          if (left_q == 4'd1) busy_q <= 1'b0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
      if (wr_i) begin
        hold_q      <= wdata_i;
        hold_full_q <= 1'b1;
      end
    end
  end

  assign hold_full_o = hold_full_q;
  assign busy_o      = busy_q;
  assign line_o      = sh_q[0];

  AST_START_NEEDS_CTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_q) |-> $past(!cts_i && hold_full_q)); // R5
  AST_START_BIT_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_q) |-> !line_o); // R3

endmodule

// File: rtl/serial_ctl_rx.sv
module serial_ctl_rx
  import serial_ctl_pkg::*;
#(
  parameter int CW = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          tick_i,
  input  logic [CW-1:0] per_m1_i,
  input  logic [CW-1:0] half_m1_i,
  input  logic          div1_i,
  input  fmt_t          fmt_i,
  input  logic          rxd_i,
  input  logic          rd_clr_i,
  output logic [7:0]    data_o,
  output logic          rdrf_o,
  output logic          ovr_o,
  output logic          fe_o,
  output logic          pe_o
);

  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_BITS} rx_state_e;

  rx_state_e     state_q;
  logic [1:0]    sync_q;
  logic          rx_s;
  logic [CW-1:0] cnt_q;
  logic [3:0]    idx_q, dbits;
  logic [7:0]    shd_q, data_q;
  logic          par_q, rdrf_q, ovr_q, fe_q, pe_q;
  logic          samp, is_stop, done, exp_par;

  assign rx_s    = sync_q[1];
  assign dbits   = fmt_i.d8 ? 4'd8 : 4'd7;
  assign is_stop = idx_q == (dbits + {3'd0, fmt_i.par_en});
  assign samp    = state_q == RX_BITS && tick_i && cnt_q == per_m1_i;
  assign done    = samp && is_stop;
  assign exp_par = (^shd_q) ^ fmt_i.par_odd;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q  <= 2'b11;
      state_q <= RX_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
      shd_q   <= '0;
      data_q  <= '0;
      par_q   <= 1'b0;
      rdrf_q  <= 1'b0;
      ovr_q   <= 1'b0;
      fe_q    <= 1'b0;
      pe_q    <= 1'b0;
    end else begin
      sync_q <= {sync_q[0], rxd_i};
      if (clr_i) begin
        state_q <= RX_IDLE;
        cnt_q   <= '0;
        rdrf_q  <= 1'b0;
        ovr_q   <= 1'b0;
        fe_q    <= 1'b0;
        pe_q    <= 1'b0;
      end else begin
        if (rd_clr_i) begin
          rdrf_q <= 1'b0;
          ovr_q  <= 1'b0;
          fe_q   <= 1'b0;
          pe_q   <= 1'b0;
        end
        unique case (state_q)
          RX_IDLE: if (tick_i && !rx_s) begin
            cnt_q   <= '0;
            idx_q   <= '0;
            shd_q   <= '0;
            state_q <= div1_i ? RX_BITS : RX_START;
          end
          RX_START: if (tick_i) begin
            if (cnt_q == half_m1_i) begin
              cnt_q   <= '0;
              state_q <= rx_s ? RX_IDLE : RX_BITS;  // high at mid-bit: noise
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          default: if (tick_i) begin
            if (samp) begin
              cnt_q <= '0;
              idx_q <= idx_q + 4'd1;
              if (idx_q < dbits) shd_q[idx_q[2:0]] <= rx_s;
              else if (!is_stop) par_q <= rx_s;
              else begin
                state_q <= RX_IDLE;
                if (rdrf_q && !rd_clr_i) ovr_q <= 1'b1;
                else begin
                  data_q <= shd_q;
                  rdrf_q <= 1'b1;
                  ovr_q  <= 1'b0;
                  fe_q   <= !rx_s;
                  pe_q   <= fmt_i.par_en && (par_q != exp_par);
                end
              end
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
        endcase
      end
    end
  end

  assign data_o = data_q;
  assign rdrf_o = rdrf_q;
  assign ovr_o  = ovr_q;
  assign fe_o   = fe_q;
  assign pe_o   = pe_q;

  AST_OVR_NEEDS_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovr_q) |-> $past(rdrf_q)); // R8
  AST_READ_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_clr_i && !clr_i && !done) |=> (!rdrf_q && !ovr_q && !fe_q && !pe_q)); // R9

endmodule

// File: rtl/serial_ctl.sv
module serial_ctl
  import serial_ctl_pkg::*;
#(
  parameter int MID_RATIO = 16,
  parameter int HI_RATIO  = 64
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sel_i,
  input  logic       wr_i,
  input  logic       rd_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  input  logic       rate_tick_i,
  output logic       txd_o,
  input  logic       rxd_i,
  output logic       rts_o,
  input  logic       cts_i,
  input  logic       dcd_i,
  output logic       irq_o
);

  localparam int CW = $clog2(HI_RATIO);
  localparam logic [CW-1:0] MID_M1  = CW'(MID_RATIO - 1);
  localparam logic [CW-1:0] HI_M1   = CW'(HI_RATIO - 1);
  localparam logic [CW-1:0] MID_H1  = CW'(MID_RATIO / 2 - 1);
  localparam logic [CW-1:0] HI_H1   = CW'(HI_RATIO / 2 - 1);

  logic [7:0]    ctrl_q, rx_data, status;
  div_e          div;
  txc_e          txc;
  fmt_t          fmt;
  logic          mreset, tdre, tx_busy, tx_full, tx_line;
  logic          rdrf, ovr, fe, pe;
  logic [CW-1:0] per_m1, half_m1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               ctrl_q <= {6'd0, DIV_MRST};
    else if (wr_i && !sel_i)   ctrl_q <= wdata_i;
  end

  assign div    = div_e'(ctrl_q[1:0]);
  assign fmt    = fmt_decode(ctrl_q[4:2]);
  assign txc    = txc_e'(ctrl_q[6:5]);
  assign mreset = div == DIV_MRST;

  always_comb begin
    unique case (div)
      DIV_MID: begin per_m1 = MID_M1; half_m1 = MID_H1; end
      DIV_HI:  begin per_m1 = HI_M1;  half_m1 = HI_H1;  end
      default: begin per_m1 = '0;     half_m1 = '0;     end
    endcase
  end

  serial_ctl_tx #(.CW(CW)) u_tx (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clr_i       (mreset),
    .tick_i      (rate_tick_i),
    .per_m1_i    (per_m1),
    .fmt_i       (fmt),
    .wr_i        (wr_i && sel_i && !mreset),
    .wdata_i     (wdata_i),
    .cts_i       (cts_i),
    .hold_full_o (tx_full),
    .busy_o      (tx_busy),
    .line_o      (tx_line)
  );

  serial_ctl_rx #(.CW(CW)) u_rx (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (mreset),
    .tick_i    (rate_tick_i),
    .per_m1_i  (per_m1),
    .half_m1_i (half_m1),
    .div1_i    (div == DIV_ONE),
    .fmt_i     (fmt),
    .rxd_i     (rxd_i),
    .rd_clr_i  (rd_i && sel_i),
    .data_o    (rx_data),
    .rdrf_o    (rdrf),
    .ovr_o     (ovr),
    .fe_o      (fe),
    .pe_o      (pe)
  );

  assign tdre    = !tx_full && !cts_i && !mreset;
  assign irq_o   = (ctrl_q[7] && (rdrf || ovr)) || (txc == TXC_IRQ && tdre);
  assign status  = {irq_o, pe, ovr, fe, cts_i, dcd_i, tdre, rdrf};
  assign rdata_o = sel_i ? rx_data : status;
  assign rts_o   = txc == TXC_RTS_HI;
  assign txd_o   = mreset ? 1'b1 : (txc == TXC_BREAK ? 1'b0 : tx_line);

  AST_MRST_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mreset && $past(mreset)) |-> (!tx_busy && !rdrf && !tx_full)); // R1

endmodule

// File: tb/serial_ctl_test.sv
`timescale 1ns/1ps
module serial_ctl_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sel = 1'b0, wr = 1'b0, rd = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       tick = 1'b1;
  logic       txd, rts, irq;
  logic       cts = 1'b0, dcd = 1'b0;
  logic       loop_en = 1'b1, rx_drv = 1'b1;
  logic       rxd;
  int         n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;
  assign rxd = loop_en ? txd : rx_drv;

  serial_ctl uut (
    .clk_i(clk), .rst_ni(rst_n), .sel_i(sel), .wr_i(wr), .rd_i(rd),
    .wdata_i(wdata), .rdata_o(rdata), .rate_tick_i(tick), .txd_o(txd),
    .rxd_i(rxd), .rts_o(rts), .cts_i(cts), .dcd_i(dcd), .irq_o(irq)
  );

  // {ctrl, byte sent, byte expected}
  localparam logic [23:0] VEC [6] = '{
    {8'h15, 8'hA5, 8'hA5},   // div16 8N1
    {8'h01, 8'hC3, 8'h43},   // div16 7E2
    {8'h1E, 8'h3C, 8'h3C},   // div64 8O1
    {8'h0C, 8'hFF, 8'h7F},   // div1  7O1
    {8'h19, 8'h80, 8'h80},   // div16 8E1
    {8'h10, 8'h5A, 8'h5A}    // div1  8N2
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic s, input logic [7:0] d);
    @(negedge clk); sel = s; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0; sel = 1'b0;
  endtask

  task automatic rd_stat(output logic [7:0] v);
    @(negedge clk); sel = 1'b0; #1 v = rdata;
  endtask

  task automatic rd_data(output logic [7:0] v);
    @(negedge clk); sel = 1'b1; rd = 1'b1; #1 v = rdata;
    @(negedge clk); rd = 1'b0; sel = 1'b0;
  endtask

  task automatic wait_rdrf(output logic ok);
    ok = 1'b0;
    for (int i = 0; i < 3000 && !ok; i++) begin
      @(negedge clk); sel = 1'b0; #1 ok = rdata[0];
    end
  endtask

  task automatic send_frame(input logic [11:0] bits, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); rx_drv = bits[i];
      repeat (15) @(negedge clk);
    end
    @(negedge clk); rx_drv = 1'b1;
  endtask

  task automatic low_run(output int len);
    len = 0;
    for (int i = 0; i < 300 && txd; i++) @(negedge clk);
    while (!txd && len < 2000) begin len++; @(negedge clk); end
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    logic [7:0] v;
    logic ok;
    int len;
    repeat (3) @(negedge clk);
    #1;
    chk("R1 reset status", rdata, 8'h00);
    chk("R1 reset line", txd, 1'b1);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // data written during master reset is dropped
    wr_reg(1'b1, 8'h77);
    wr_reg(1'b0, 8'h15);
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (!txd) ok = 1'b0;
    end
    chk("R1 no tx after reset write", txd, 1'b1);
    rd_stat(v);
    chk("R1 tdre after leaving reset", v, 8'h02);

    // loopback table
    for (int k = 0; k < 6; k++) begin
      wr_reg(1'b0, 8'h03);
      wr_reg(1'b0, VEC[k][23:16]);
      wr_reg(1'b1, VEC[k][15:8]);
      wait_rdrf(ok);
      chk("R12 rdrf after loopback", ok, 1'b1);
      rd_stat(v);
      chk("R3 no errors", v[6:4], 3'b000);
      rd_data(v);
      chk("R3 R2 loopback data", v, VEC[k][7:0]);
      rd_stat(v);
      chk("R9 rdrf cleared by read", v[0], 1'b0);
    end

    // bit period: start + 8 zero data bits low
    wr_reg(1'b0, 8'h03); wr_reg(1'b0, 8'h16); wr_reg(1'b1, 8'h00);
    low_run(len); chk("R2 div64 low run", len, 576);
    wr_reg(1'b0, 8'h03); wr_reg(1'b0, 8'h15); wr_reg(1'b1, 8'hFE);
    low_run(len); chk("R2 div16 low run LSB first", len, 32);
    wr_reg(1'b0, 8'h03); wr_reg(1'b0, 8'h14); wr_reg(1'b1, 8'h00);
    low_run(len); chk("R2 div1 low run", len, 9);

    // master reset with data held
    wr_reg(1'b0, 8'h15); wr_reg(1'b1, 8'h21);
    wait_rdrf(ok);
    wr_reg(1'b0, 8'h63);
    rd_stat(v);
    chk("R1 mid-run reset flags", v[1:0], 2'b00);
    chk("R1 reset overrides break", txd, 1'b1);

    // break and RTS
    wr_reg(1'b0, 8'h75); @(negedge clk);
    chk("R4 break line", txd, 1'b0);
    chk("R4 rts low on break", rts, 1'b0);
    wr_reg(1'b0, 8'h55); @(negedge clk);
    chk("R4 rts high", rts, 1'b1);
    wr_reg(1'b0, 8'h15); @(negedge clk);
    chk("R4 rts low", rts, 1'b0);
    chk("R4 idle line", txd, 1'b1);

    // CTS gating and modem status bits
    cts = 1'b1; dcd = 1'b1;
    rd_stat(v);
    chk("R11 status cts dcd", v[3:2], 2'b11);
    chk("R5 tdre forced low", v[1], 1'b0);
    wr_reg(1'b1, 8'h6B);
    ok = 1'b1;
    for (int i = 0; i < 200; i++) begin @(negedge clk); if (!txd) ok = 1'b0; end
    chk("R5 no start while cts high", ok, 1'b1);
    cts = 1'b0; dcd = 1'b0;
    wait_rdrf(ok);
    rd_data(v);
    chk("R5 char sent after cts low", v, 8'h6B);
    rd_stat(v);
    chk("R11 status cts dcd low", v[3:2], 2'b00);

    // overrun
    wr_reg(1'b1, 8'h11);
    for (int i = 0; i < 50; i++) begin rd_stat(v); if (v[1]) break; end
    wr_reg(1'b1, 8'h22);
    repeat (500) @(negedge clk);
    rd_stat(v);
    chk("R8 overrun set", v[5], 1'b1);
    chk("R8 rdrf still set", v[0], 1'b1);
    rd_data(v);
    chk("R8 first char kept", v, 8'h11);
    rd_stat(v);
    chk("R9 overrun cleared", v[5], 1'b0);

    // noise start rejection, then a clean frame
    loop_en = 1'b0;
    @(negedge clk); rx_drv = 1'b0;
    repeat (4) @(negedge clk); rx_drv = 1'b1;
    repeat (300) @(negedge clk);
    rd_stat(v);
    chk("R6 short pulse dropped", v[0], 1'b0);
    send_frame({2'b11, 1'b1, 8'h3C, 1'b0}, 10);
    wait_rdrf(ok);
    rd_data(v);
    chk("R6 mid-bit sampled char", v, 8'h3C);

    // framing error
    send_frame({2'b11, 1'b0, 8'h55, 1'b0}, 10);
    wait_rdrf(ok);
    rd_stat(v);
    chk("R7 framing error", v[4], 1'b1);
    rd_data(v);
    chk("R7 framed data", v, 8'h55);
    rd_stat(v);
    chk("R9 fe cleared", v[4], 1'b0);

    // parity error in 8E1
    wr_reg(1'b0, 8'h19);
    send_frame({1'b1, 1'b1, 1'b1, 8'h55, 1'b0}, 11);
    wait_rdrf(ok);
    rd_stat(v);
    chk("R7 parity error", v[6:4], 3'b100);
    rd_data(v);
    rd_stat(v);
    chk("R9 pe cleared", v[6], 1'b0);
    send_frame({1'b1, 1'b1, 1'b0, 8'h55, 1'b0}, 11);
    wait_rdrf(ok);
    rd_stat(v);
    chk("R7 good parity", v[6:4], 3'b000);
    rd_data(v);
    loop_en = 1'b1;

    // interrupts
    wr_reg(1'b0, 8'h35); #1;
    chk("R10 tx irq", irq, 1'b1);
    rd_stat(v);
    chk("R10 status bit7", v[7], 1'b1);
    cts = 1'b1; #1;
    chk("R10 tx irq gated by cts", irq, 1'b0);
    cts = 1'b0;
    wr_reg(1'b0, 8'h95); wr_reg(1'b1, 8'h42);
    wait_rdrf(ok);
    chk("R10 rx irq", irq, 1'b1);
    rd_data(v); #1;
    chk("R10 rx irq cleared", irq, 1'b0);
    wr_reg(1'b0, 8'h15); wr_reg(1'b1, 8'h43);
    wait_rdrf(ok); #1;
    chk("R10 rx irq disabled", irq, 1'b0);
    rd_stat(v);
    chk("R10 status bit7 low", v[7], 1'b0);

    summary();
    $finish;
  end

endmodule